// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial characters from a single line. It samples the line once per sample tick. There are sixteen ticks per bit in normal mode and eight in double-speed mode. Every start bit is checked before it is accepted, so a short low glitch cannot begin a false character. Each data bit and the parity bit are decided by a two-out-of-three vote over the samples at the middle of the bit. The character length is selectable from five to nine bits, and parity can be none, even or odd.

A finished character goes into a two-entry buffer together with its own framing-error and parity-error flags. If the buffer is full, the character waits in a holding register. The host pops the oldest entry with a read strobe. The error outputs always describe the entry at the head of the buffer. A character lost to a full buffer sets an overrun flag. Clearing the enable discards everything and holds the receiver idle.

Sampling is done by a state machine with five states. `IDLE` tracks the previous sample. A high sample followed by a low sample moves it to `START`. `START` votes on the start bit. If the vote is high, it returns to `IDLE` (reject). Otherwise it moves to `DATA` at the bit end. `DATA` moves to `PARITY` after the last data bit when parity is on, or to `STOP` when it is off. `PARITY` moves to `STOP` at its bit end. `STOP` returns to `IDLE` at its vote point and marks the character complete. Clearing the enable forces `IDLE` from any state.

Top module: `uart_os_rx`

## Requirements
- R1: A start is only considered after a high sample followed by a low sample. That low sample is sample 1. The start is accepted when at most one of samples 8, 9, 10 (normal) or 4, 5, 6 (double speed) is high. Otherwise the receiver ignores the pulse and needs a new high-then-low pair before it can start again.
- R2: With `dbl_speed`=0 each bit spans 16 ticks. With `dbl_speed`=1 each bit spans 8 ticks.
- R3: Each data bit and the parity bit take the majority value of the three middle samples of that bit (the same positions as in R1). A single flipped sample does not change the result.
- R4: `len_sel` sets the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, and 4 to 7 give 9. Data arrives least significant bit first. It appears right-aligned on `rx_data` with the unused upper bits at zero.
- R5: `par_sel` selects the parity mode: 00 or 01 means none, 10 means even, 11 means odd. Even parity expects the XOR of the data bits. Odd parity expects its inverse. A mismatch sets `parity_err` for that character only.
- R6: The character ends at the middle of the first stop bit. A low stop sample sets `frame_err` for that character. A second stop bit is never examined, so a new start may directly follow the first stop bit.
- R7: The buffer holds two characters and releases them oldest first. A `rd_pop` with data available removes the head. `rx_data`, `frame_err` and `parity_err` reflect the current head.
- R8: `rx_avail` is high exactly while at least one unread character is buffered.
- R9: If both buffer entries are full and a character is waiting in the holding register, the next accepted start sets `overrun` and discards the waiting character. The next pop clears `overrun`.
- R10: While `rx_en` is low, the buffer and holding register are emptied, `rx_avail` and `overrun` are low, and the receiver stays in `IDLE`.
- R11: After reset, `rx_avail`, `overrun`, `frame_err` and `parity_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idle high, asynchronous to clk |
| sample_tick | input | 1 | One-cycle pulse per oversample |
| dbl_speed | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| len_sel | input | 3 | Data length code (R4) |
| par_sel | input | 2 | Parity mode (R5) |
| rx_en | input | 1 | Receiver enable; low flushes |
| rd_pop | input | 1 | Pop the head character |
| rx_data | output | 9 | Head character data |
| frame_err | output | 1 | Head character had a low stop bit |
| parity_err | output | 1 | Head character failed parity |
| overrun | output | 1 | A character was lost |
| rx_avail | output | 1 | Unread data present |

## Verification
The assertions assume the following about the inputs:
- `sample_tick` is a single-cycle pulse.
- `dbl_speed`, `len_sel` and `par_sel` hold still while a character is in flight, so the sample counter stays inside the bit length.
- `rd_pop` is honoured only when data is available.

The stimulus keeps to these assumptions. It raises the tick on every other clock. It changes the format only while the line has been idle for at least one full bit. Every line transition lands on a tick boundary, so each bit or glitch lasts a whole number of samples.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
    localparam int DATA_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_entry_t;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_fsm.sv
module uart_os_rx_fsm
    import uart_os_rx_pkg::*;
#(
    parameter int OSR_NORM = 16,
    parameter int OSR_FAST = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  logic      line,
    input  logic      dbl,
    input  logic [2:0] len_sel,
    input  logic [1:0] par_sel,
    output logic      start_ok,
    output logic      done,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OSR_NORM + 1);
    localparam int IW = $clog2(DATA_W);

    rx_state_e state, nxt;
    logic [CW-1:0] cnt, osr, mid, vote_pt, s_now;
    logic [IW-1:0] bit_idx, last_idx;
    logic [DATA_W-1:0] shreg;
    logic last, v_a, v_b, par_bit, vote, at_vote, at_end;
    logic par_en, par_odd;

    assign par_en  = par_sel[1];
    assign par_odd = par_sel[0];
    assign osr     = dbl ? CW'(OSR_FAST) : CW'(OSR_NORM);
    assign mid     = (osr >> 1) + CW'(1);
    assign vote_pt = mid + CW'(1);
    assign s_now   = (cnt == osr) ? CW'(1) : cnt + CW'(1);
    assign at_vote = tick && (s_now == vote_pt);
    assign at_end  = tick && (cnt == osr);
    assign vote    = (v_a & v_b) | (v_a & line) | (v_b & line);

    always_comb begin
        unique case (len_sel)
            3'd0:    last_idx = IW'(4);
            3'd1:    last_idx = IW'(5);
            3'd2:    last_idx = IW'(6);
            3'd3:    last_idx = IW'(7);
            default: last_idx = IW'(8);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && last && !line) nxt = ST_START;
            ST_START:  if (at_vote && vote) nxt = ST_IDLE;
                       else if (at_end) nxt = ST_DATA;
            ST_DATA:   if (at_end && bit_idx == last_idx)
                           nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_end) nxt = ST_STOP;
            ST_STOP:   if (at_vote) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // sample counter, vote capture and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; last <= 1'b0; v_a <= 1'b1; v_b <= 1'b1;
            bit_idx <= '0; shreg <= '0; par_bit <= 1'b0;
        end else if (!en) begin
            cnt <= '0; last <= 1'b0; bit_idx <= '0; shreg <= '0;
        end else if (tick) begin
            if (state == ST_IDLE) begin
                last    <= line;
                cnt     <= CW'(1);
                bit_idx <= '0;
                shreg   <= '0;
            end else begin
                last <= 1'b0;
                cnt  <= s_now;
                if (s_now == mid - CW'(1)) v_a <= line;
                if (s_now == mid)          v_b <= line;
                if (state == ST_DATA && s_now == vote_pt) shreg[bit_idx] <= vote;
                if (state == ST_DATA && cnt == osr) bit_idx <= bit_idx + IW'(1);
                if (state == ST_PARITY && s_now == vote_pt) par_bit <= vote;
            end
        end
    end

    // outputs
    always_comb begin
        start_ok   = (state == ST_START) && at_vote && !vote;
        done       = (state == ST_STOP) && at_vote;
        entry.data = shreg;
        entry.ferr = !vote;
        entry.perr = par_en && (par_bit != ((^shreg) ^ par_odd));
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt >= CW'(1) && cnt <= osr));
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));
endmodule

// File: rtl/uart_os_rx_fifo.sv
module uart_os_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [NW-1:0] count;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0;
        end else if (flush) begin
            wp <= '0; rp <= '0; count <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            count <= count + NW'(push) - NW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign empty = (count == '0);
    assign full  = (count == NW'(DEPTH));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < NW'(DEPTH)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int OSR_NORM  = 16,
    parameter int OSR_FAST  = 8,
    parameter int BUF_DEPTH = 2,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              sample_tick,
    input  logic              dbl_speed,
    input  logic [2:0]        len_sel,
    input  logic [1:0]        par_sel,
    input  logic              rx_en,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              rx_avail
);
    localparam int EW = $bits(rx_entry_t);

    logic      line_s, start_ok, done, pop, push, empty, full;
    logic      pend_v, ovr;
    rx_entry_t cur, pend_e, head;

    uart_os_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s));

    uart_os_rx_fsm #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(sample_tick),
        .line(line_s), .dbl(dbl_speed), .len_sel(len_sel), .par_sel(par_sel),
        .start_ok(start_ok), .done(done), .entry(cur));

    assign pop  = rd_pop && !empty;
    assign push = pend_v && !full;

    uart_os_rx_fifo #(.DEPTH(BUF_DEPTH), .W(EW)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push),
        .wdata(pend_e), .pop(pop), .rdata(head), .empty(empty), .full(full));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v <= 1'b0; pend_e <= '0; ovr <= 1'b0;
        end else if (!rx_en) begin
            pend_v <= 1'b0; ovr <= 1'b0;
        end else begin
            if (done) begin
                pend_v <= 1'b1;
                pend_e <= cur;
            end else if (start_ok && pend_v && full && !pop) begin
                pend_v <= 1'b0;
            end else if (push) begin
                pend_v <= 1'b0;
            end
            if (start_ok && pend_v && full && !pop) ovr <= 1'b1;
            else if (pop)                           ovr <= 1'b0;
        end
    end

    assign rx_data    = empty ? '0 : head.data;
    assign frame_err  = !empty && head.ferr;
    assign parity_err = !empty && head.perr;
    assign overrun    = ovr;
    assign rx_avail   = !empty;

    assert_pend_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pend_v);
    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(pend_v && full));
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rx = 1'b1, tick = 1'b0, dbl = 1'b0, en = 1'b0, rd = 1'b0;
    logic [2:0] len = 3'd3;
    logic [1:0] par = 2'b00;
    logic [8:0] rx_data;
    logic       frame_err, parity_err, overrun, rx_avail;
    int         n_chk = 0, n_fail = 0;

    uart_os_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .sample_tick(tick),
        .dbl_speed(dbl), .len_sel(len), .par_sel(par), .rx_en(en),
        .rd_pop(rd), .rx_data(rx_data), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun), .rx_avail(rx_avail));

    always #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int osr();
        return dbl ? 8 : 16;
    endfunction

    task automatic drive_bit(input logic v, input bit glitch);
        for (int t = 0; t < osr(); t++) begin
            rx = (glitch && t == osr() / 2) ? ~v : v;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic idle_bits(input int n);
        rx = 1'b1;
        repeat (n * osr() * 2) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nb, input bit bad_par,
                        input bit bad_stop, input int nstop, input int gbit);
        logic [8:0] m;
        logic p;
        m = d & 9'((1 << nb) - 1);
        p = (^m) ^ par[0];
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i], i == gbit);
        if (par[1]) drive_bit(p ^ bad_par, 1'b0);
        drive_bit(!bad_stop, 1'b0);
        if (nstop == 2) drive_bit(1'b1, 1'b0);
        rx = 1'b1;
    endtask

    task automatic pop_one();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 avail", rx_avail, 0);
        check("R11 overrun", overrun, 0);
        check("R11 frame_err", frame_err, 0);
        check("R11 parity_err", parity_err, 0);
    endtask

    task automatic t_basic();
        len = 3'd3; par = 2'b00;
        send(9'h0A5, 8, 0, 0, 1, -1); idle_bits(1);
        check("R4 8-bit data", rx_data, 9'h0A5);
        check("R8 avail set", rx_avail, 1);
        check("R6 no frame_err", frame_err, 0);
        pop_one();
        check("R8 avail clear", rx_avail, 0);
    endtask

    task automatic t_formats();
        len = 3'd0; par = 2'b10; idle_bits(1);
        send(9'h1F5, 5, 0, 0, 1, -1); idle_bits(1);
        check("R4 5-bit masked", rx_data, 9'h015);
        check("R5 even ok", parity_err, 0);
        pop_one();
        len = 3'd4; par = 2'b11; idle_bits(1);
        send(9'h1A3, 9, 0, 0, 2, -1); idle_bits(1);
        check("R4 9-bit data", rx_data, 9'h1A3);
        check("R5 odd ok", parity_err, 0);
        pop_one();
    endtask

    task automatic t_parity_order();
        len = 3'd2; par = 2'b10; idle_bits(1);
        send(9'h05B, 7, 1, 0, 1, -1); idle_bits(1);
        send(9'h033, 7, 0, 0, 1, -1); idle_bits(1);
        check("R5 parity_err head", parity_err, 1);
        check("R7 oldest first", rx_data, 9'h05B);
        pop_one();
        check("R7 second entry", rx_data, 9'h033);
        check("R5 per-frame flag", parity_err, 0);
        pop_one();
        check("R8 empty after two", rx_avail, 0);
    endtask

    task automatic t_frame_err();
        len = 3'd3; par = 2'b00; idle_bits(1);
        send(9'h0E7, 8, 0, 1, 1, -1); idle_bits(1);
        check("R6 frame_err set", frame_err, 1);
        check("R6 data kept", rx_data, 9'h0E7);
        pop_one();
        send(9'h03C, 8, 0, 0, 1, -1);
        send(9'h0C3, 8, 0, 0, 1, -1); idle_bits(1);
        check("R6 back-to-back first", rx_data, 9'h03C);
        check("R6 first stop good", frame_err, 0);
        pop_one();
        check("R6 back-to-back second", rx_data, 9'h0C3);
        pop_one();
    endtask

    task automatic t_overrun();
        send(9'h011, 8, 0, 0, 1, -1); idle_bits(1);
        send(9'h022, 8, 0, 0, 1, -1); idle_bits(1);
        send(9'h033, 8, 0, 0, 1, -1); idle_bits(1);
        check("R9 no overrun yet", overrun, 0);
        send(9'h044, 8, 0, 0, 1, -1); idle_bits(1);
        check("R9 overrun set", overrun, 1);
        check("R9 head kept", rx_data, 9'h011);
        pop_one();
        check("R9 overrun cleared by pop", overrun, 0);
        check("R9 second kept", rx_data, 9'h022);
        pop_one();
        check("R9 waiting frame dropped", rx_data, 9'h044);
        pop_one();
        check("R8 empty", rx_avail, 0);
    endtask

    task automatic t_noise();
        rx = 1'b0;
        repeat (6) @(negedge clk);
        idle_bits(2);
        check("R1 spike rejected", rx_avail, 0);
        send(9'h05A, 8, 0, 0, 1, -1); idle_bits(1);
        check("R1 rearm after reject", rx_data, 9'h05A);
        pop_one();
    endtask

    task automatic t_glitch();
        send(9'h000, 8, 0, 0, 1, 3); idle_bits(1);
        check("R3 glitch outvoted", rx_data, 9'h000);
        check("R3 avail", rx_avail, 1);
        pop_one();
        send(9'h0FF, 8, 0, 0, 1, 5); idle_bits(1);
        check("R3 glitch outvoted high", rx_data, 9'h0FF);
        pop_one();
    endtask

    task automatic t_double();
        dbl = 1'b1; idle_bits(2);
        send(9'h0C6, 8, 0, 0, 1, -1); idle_bits(1);
        check("R2 double-speed data", rx_data, 9'h0C6);
        pop_one();
        rx = 1'b0;
        repeat (4) @(negedge clk);
        idle_bits(2);
        check("R1 double-speed spike rejected", rx_avail, 0);
        dbl = 1'b0; idle_bits(2);
    endtask

    task automatic t_enable();
        send(9'h011, 8, 0, 0, 1, -1); idle_bits(1);
        send(9'h022, 8, 0, 0, 1, -1); idle_bits(1);
        send(9'h033, 8, 0, 0, 1, -1); idle_bits(1);
        send(9'h044, 8, 0, 0, 1, -1); idle_bits(1);
        check("R9 overrun before disable", overrun, 1);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 flush avail", rx_avail, 0);
        check("R10 flush overrun", overrun, 0);
        send(9'h099, 8, 0, 0, 1, -1); idle_bits(1);
        check("R10 ignored while disabled", rx_avail, 0);
        en = 1'b1; idle_bits(1);
        send(9'h077, 8, 0, 0, 1, -1); idle_bits(1);
        check("R10 works after re-enable", rx_data, 9'h077);
        pop_one();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b1;
        idle_bits(1);
        t_basic();
        t_formats();
        t_parity_order();
        t_frame_err();
        t_overrun();
        t_noise();
        t_glitch();
        t_double();
        t_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule